// File: doc/BRIEF.md
# SPI Port Controller with Sticky Status Flags

This block is a byte-wide SPI port for a small processor bus. Software reaches it through three byte registers. A control/status register holds the flags, the slave-select mode and the enable bit. A data register is written to load the one-byte transmit buffer and read to fetch the receive buffer. A configuration register holds the master-enable bit. Every transfer is 8 bits, MSB first. SCK idles low and data is sampled on its rising edge.

As master, the block produces SCK from the system clock. The SCK half period is `HALF_DIV` clock cycles. As slave, it samples SCK, MOSI and the slave-select input through two-flop synchronizers, so each external SCK phase must last at least three system clocks. The slave-select line has three modes. In 3-wire mode it is ignored. In 4-wire input mode it selects the slave, and a low level seen while acting as master is a fault. In single-master mode it becomes an output that copies bit 0 of the mode field.

The flags report transfer done, write collision, mode fault and slave receive overrun. Each flag stays set until software writes it to 0. One interrupt output is the OR of the four flags.

Top module: `spi_ctrl`

## Requirements
- R1: After reset the control register (address 0) reads 8'h06: transfer-done bit7, collision bit6, mode-fault bit5, overrun bit4, slave-select mode bits[3:2]=01, transmit-buffer-empty bit1=1, enable bit0=0. The configuration register (address 2, master enable in bit0) reads 0, and irq_o, sck_oe_o and nss_oe_o are 0.
- R2: With enable and master set and the shifter idle, a write to the data register (address 1) clears bit1. The byte moves into the shifter on the next cycle and bit1 returns to 1. The block then gives 8 SCK rising edges with SCK idling low and MOSI MSB first. It captures MISO on each rising edge into the receive buffer and sets bit7.
- R3: As a selected slave, the block takes a buffered byte into the shifter while idle and sets bit1. On each synchronized SCK rising edge it shifts in MOSI while MISO presents its byte MSB first. After 8 edges the byte goes to the receive buffer and bit7 is set.
- R4: A data-register write while a transfer is in progress sets bit6 and is discarded. The transmit buffer and the byte in flight are unchanged.
- R5: With enable set, master set and mode 01, a low slave-select input sets bit5 and clears the master-enable bit. SCK and MOSI output enables then drop.
- R6: In slave mode, a finished transfer that finds the receive buffer unread sets bit4. The old byte is kept and the new byte is dropped. Reading the data register frees the buffer.
- R7: Mode 00 ignores the slave-select input (a slave is always selected) and does not drive it. Mode 01 uses it as an active-low select input. Mode 1x drives nss_o with mode bit 0, with nss_oe_o high while enabled.
- R8: Flag bits are sticky. A control write loads bits 7..4, with a hardware set winning in the same cycle. Bit1 ignores writes.
- R9: irq_o is high exactly when any of bits 7..4 is set.
- R10: With enable clear, no transfer starts and sck_oe_o, mosi_oe_o, miso_oe_o and nss_oe_o stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register select: 0 control, 1 data, 2 configuration |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe (a data read frees the receive buffer) |
| rdata_o | output | 8 | Read data for addr_i |
| irq_o | output | 1 | Interrupt, OR of the flags |
| sck_i | input | 1 | SCK from external master |
| sck_o | output | 1 | SCK when master |
| sck_oe_o | output | 1 | SCK output enable |
| mosi_i | input | 1 | MOSI from external master |
| mosi_o | output | 1 | MOSI when master |
| mosi_oe_o | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO from external slave |
| miso_o | output | 1 | MISO when slave |
| miso_oe_o | output | 1 | MISO output enable |
| nss_i | input | 1 | Slave-select input |
| nss_o | output | 1 | Slave-select output value |
| nss_oe_o | output | 1 | Slave-select output enable |

## Verification
The assertions check the following on every cycle:
- flag stickiness;
- set-on-collision with an unchanged transmit buffer;
- the mode fault dropping master;
- the overrun keeping the old byte;
- SCK idling low;
- the buffer-to-shifter handoff timing;
- silent pins when disabled or in 3-wire mode.

Only the bench scenarios can show the serial data itself: the bit order on MOSI and MISO, the captured receive byte under looped and inverted MISO, and the slave path through the synchronizers. The same holds for the exact byte that survives an overrun or a collision.

// File: rtl/spi_pkg.sv
package spi_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_DATA = 2'd1,
    ADDR_CFG  = 2'd2
  } reg_addr_e;

  localparam int unsigned BYTE_W = 8;
  localparam logic [7:0]  CTRL_RESET = 8'h06;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/spi_nss_ctl.sv
module spi_nss_ctl (
  input  logic       en_i,
  input  logic       mst_i,
  input  logic [1:0] mode_i,
  input  logic       nss_s_i,
  output logic       nss_o,
  output logic       nss_oe_o,
  output logic       sel_o,
  output logic       fault_o
);
  always_comb begin
    nss_o    = 1'b1;
    nss_oe_o = 1'b0;
    sel_o    = 1'b0;
    fault_o  = 1'b0;
    unique casez (mode_i)
      2'b00: sel_o = 1'b1;
      2'b01: begin
        sel_o   = !nss_s_i;
        fault_o = en_i && mst_i && !nss_s_i;
      end
      default: begin
        nss_o    = mode_i[0];
        nss_oe_o = en_i;
        sel_o    = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng import spi_pkg::*; #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              mst_i,
  input  logic              sel_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              miso_i,
  input  logic              sck_s_i,
  input  logic              mosi_s_i,
  output logic              take_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              sck_o,
  output logic              sdo_o
);
  localparam int unsigned DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam int unsigned CNT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DIV_W-1:0]  div_q;
  logic              busy_q, sck_q, samp_q, sck_d_q, done_q;
  logic              m_act, s_act, rise, last_bit;

  assign m_act    = en_i && mst_i;
  assign s_act    = en_i && !mst_i && sel_i;
  assign rise     = sck_s_i && !sck_d_q;
  assign last_bit = (cnt_q == CNT_W'(BYTE_W - 1));

  assign take_o = (m_act && !busy_q && load_i) ||
                  (s_act && !rise && cnt_q == '0 && load_i);
  assign busy_o = busy_q || (s_act && cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      div_q   <= '0;
      busy_q  <= 1'b0;
      sck_q   <= 1'b0;
      samp_q  <= 1'b0;
      sck_d_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      sck_d_q <= sck_s_i;
      done_q  <= 1'b0;
      if (!m_act && !s_act) begin
        busy_q <= 1'b0;
        sck_q  <= 1'b0;
        cnt_q  <= '0;
        div_q  <= '0;
      end else if (m_act) begin
        if (!busy_q) begin
          div_q <= '0;
          sck_q <= 1'b0;
          cnt_q <= '0;
          if (load_i) begin
            sh_q   <= tx_byte_i;
            busy_q <= 1'b1;
          end
        end else if (div_q == DIV_LAST) begin
          div_q <= '0;
          if (!sck_q) begin
            sck_q  <= 1'b1;
            samp_q <= miso_i;
          end else begin
            sck_q <= 1'b0;
            sh_q  <= {sh_q[BYTE_W-2:0], samp_q};
            cnt_q <= cnt_q + 1'b1;
            if (last_bit) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end else begin
        busy_q <= 1'b0;
        sck_q  <= 1'b0;
        if (rise) begin
          sh_q  <= {sh_q[BYTE_W-2:0], mosi_s_i};
          cnt_q <= cnt_q + 1'b1;
          if (last_bit) done_q <= 1'b1;
        end else if (cnt_q == '0 && load_i) begin
          sh_q <= tx_byte_i;
        end
      end
    end
  end

  assign done_o    = done_q;
  assign rx_byte_o = sh_q;
  assign sck_o     = sck_q;
  assign sdo_o     = sh_q[BYTE_W-1];
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl import spi_pkg::*; #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       we_i,
  input  logic       re_i,
  output logic [7:0] rdata_o,
  output logic       irq_o,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe_o,
  input  logic       mosi_i,
  output logic       mosi_o,
  output logic       mosi_oe_o,
  input  logic       miso_i,
  output logic       miso_o,
  output logic       miso_oe_o,
  input  logic       nss_i,
  output logic       nss_o,
  output logic       nss_oe_o
);
  logic       spif_q, wcol_q, modf_q, ovr_q, txe_q, en_q, mst_q, rx_full_q;
  logic [1:0] mode_q;
  logic [7:0] tx_buf_q, rx_buf_q, rx_byte;
  logic       sck_s, mosi_s, nss_s;
  logic       sel, fault, take, busy, done, sh_sck, sdo;
  logic       ctrl_wr, data_wr, cfg_wr, data_rd, data_ok, ovr_set;

  assign ctrl_wr = we_i && addr_i == ADDR_CTRL;
  assign data_wr = we_i && addr_i == ADDR_DATA;
  assign cfg_wr  = we_i && addr_i == ADDR_CFG;
  assign data_rd = re_i && addr_i == ADDR_DATA;
  assign data_ok = data_wr && !busy;
  assign ovr_set = done && !mst_q && rx_full_q && !data_rd;

  spi_sync #(.WIDTH(3)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sck_i, mosi_i, nss_i}),
    .q_o    ({sck_s, mosi_s, nss_s})
  );

  spi_nss_ctl u_nss (
    .en_i     (en_q),
    .mst_i    (mst_q),
    .mode_i   (mode_q),
    .nss_s_i  (nss_s),
    .nss_o    (nss_o),
    .nss_oe_o (nss_oe_o),
    .sel_o    (sel),
    .fault_o  (fault)
  );

  spi_shift_eng #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_q),
    .mst_i     (mst_q),
    .sel_i     (sel),
    .load_i    (!txe_q),
    .tx_byte_i (tx_buf_q),
    .miso_i    (miso_i),
    .sck_s_i   (sck_s),
    .mosi_s_i  (mosi_s),
    .take_o    (take),
    .busy_o    (busy),
    .done_o    (done),
    .rx_byte_o (rx_byte),
    .sck_o     (sh_sck),
    .sdo_o     (sdo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {spif_q, wcol_q, modf_q, ovr_q, mode_q, txe_q, en_q} <= CTRL_RESET;
      mst_q     <= 1'b0;
      tx_buf_q  <= '0;
      rx_buf_q  <= '0;
      rx_full_q <= 1'b0;
    end else begin
      // hardware set wins over a software write in the same cycle
      spif_q <= done               | (ctrl_wr ? wdata_i[7] : spif_q);
      wcol_q <= (data_wr && busy)  | (ctrl_wr ? wdata_i[6] : wcol_q);
      modf_q <= fault              | (ctrl_wr ? wdata_i[5] : modf_q);
      ovr_q  <= ovr_set            | (ctrl_wr ? wdata_i[4] : ovr_q);
      if (ctrl_wr) begin
        mode_q <= wdata_i[3:2];
        en_q   <= wdata_i[0];
      end
      if (fault)       mst_q <= 1'b0;
      else if (cfg_wr) mst_q <= wdata_i[0];
      if (data_ok) begin
        tx_buf_q <= wdata_i;
        txe_q    <= 1'b0;
      end else if (take) begin
        txe_q    <= 1'b1;
      end
      if (done && !ovr_set) begin
        rx_buf_q  <= rx_byte;
        rx_full_q <= 1'b1;
      end else if (data_rd) begin
        rx_full_q <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = {spif_q, wcol_q, modf_q, ovr_q, mode_q, txe_q, en_q};
      ADDR_DATA: rdata_o = rx_buf_q;
      ADDR_CFG:  rdata_o = {7'b0, mst_q};
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o     = spif_q | wcol_q | modf_q | ovr_q;
  assign sck_oe_o  = en_q && mst_q;
  assign mosi_oe_o = en_q && mst_q;
  assign sck_o     = sh_sck;
  assign mosi_o    = mst_q ? sdo : 1'b0;
  assign miso_o    = sdo;
  assign miso_oe_o = en_q && !mst_q && sel;
endmodule

// File: rtl/spi_ctrl_chk.sv
module spi_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en,
  input logic       mst,
  input logic [1:0] mode,
  input logic       txe,
  input logic       busy,
  input logic       spif,
  input logic       wcol,
  input logic       modf,
  input logic       ovr,
  input logic       done,
  input logic       fault,
  input logic       rx_full,
  input logic       data_wr,
  input logic       data_rd,
  input logic       ctrl_wr,
  input logic       we,
  input logic       sck_o,
  input logic       sck_oe,
  input logic       mosi_oe,
  input logic       miso_oe,
  input logic       nss_oe,
  input logic [7:0] rx_buf,
  input logic [7:0] tx_buf
);
  AST_TXE_HANDOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode[1] && en && mst && !busy && !txe && !we |=> txe && busy); // R2
  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_oe && !busy |-> !sck_o); // R2
  AST_WCOL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr && busy |=> wcol && $stable(tx_buf)); // R4
  AST_FAULT_DROPS_MASTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault |=> modf && !mst && !sck_oe); // R5
  AST_OVR_KEEPS_OLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && !mst && rx_full && !data_rd |=> ovr && $stable(rx_buf)); // R6
  AST_NSS_3WIRE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode == 2'b00 |-> !nss_oe); // R7
  AST_SPIF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spif && !ctrl_wr |=> spif); // R8
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr && !ctrl_wr |=> ovr); // R8
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !sck_oe && !mosi_oe && !miso_oe && !nss_oe); // R10
endmodule

bind spi_ctrl spi_ctrl_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en      (en_q),
  .mst     (mst_q),
  .mode    (mode_q),
  .txe     (txe_q),
  .busy    (busy),
  .spif    (spif_q),
  .wcol    (wcol_q),
  .modf    (modf_q),
  .ovr     (ovr_q),
  .done    (done),
  .fault   (fault),
  .rx_full (rx_full_q),
  .data_wr (data_wr),
  .data_rd (data_rd),
  .ctrl_wr (ctrl_wr),
  .we      (we_i),
  .sck_o   (sck_o),
  .sck_oe  (sck_oe_o),
  .mosi_oe (mosi_oe_o),
  .miso_oe (miso_oe_o),
  .nss_oe  (nss_oe_o),
  .rx_buf  (rx_buf_q),
  .tx_buf  (tx_buf_q)
);

// File: tb/spi_ctrl_tb.sv
module spi_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // {tx byte, invert MISO, expected rx byte}
  localparam logic [16:0] MVEC [NVEC] = '{
    {8'hA5, 1'b0, 8'hA5},
    {8'h3C, 1'b1, 8'hC3},
    {8'h80, 1'b0, 8'h80},
    {8'h01, 1'b1, 8'hFE},
    {8'hFF, 1'b0, 8'hFF}
  };

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       we = 1'b0, re = 1'b0;
  logic       irq, sck_in = 1'b0, sck_out, sck_oe, mosi_in = 1'b0, mosi_out, mosi_oe;
  logic       miso_in, miso_out, miso_oe, nss_in = 1'b1, nss_out, nss_oe;
  logic       miso_inv = 1'b0;
  int         errors = 0, checks = 0;
  int         ecnt = 0;
  logic [7:0] cap = '0;

  assign miso_in = miso_inv ? ~mosi_out : mosi_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge sck_out) begin
    cap  <= {cap[6:0], mosi_out};
    ecnt <= ecnt + 1;
  end

  spi_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .irq_o(irq),
    .sck_i(sck_in), .sck_o(sck_out), .sck_oe_o(sck_oe),
    .mosi_i(mosi_in), .mosi_o(mosi_out), .mosi_oe_o(mosi_oe),
    .miso_i(miso_in), .miso_o(miso_out), .miso_oe_o(miso_oe),
    .nss_i(nss_in), .nss_o(nss_out), .nss_oe_o(nss_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; re = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done();
    logic [7:0] c;
    for (int i = 0; i < 300; i++) begin
      rd(2'd0, c);
      if (c[7]) break;
    end
  endtask

  task automatic slave_xfer(input logic [7:0] sb, output logic [7:0] seen);
    for (int i = 7; i >= 0; i--) begin
      mosi_in = sb[i];
      idle(4);
      seen[i] = miso_out;
      sck_in = 1'b1;
      idle(4);
      sck_in = 1'b0;
    end
    idle(6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] r, seen;
    int e0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rd(2'd0, r); chk("R1 ctrl", r, 8'h06);
    rd(2'd2, r); chk("R1 cfg", r, 8'h00);
    chk("R1 irq/oe", {5'b0, irq, sck_oe, nss_oe}, 8'h00);

    // R2 master transfers from vector table, mode 10 single master
    wr(2'd0, 8'h09);
    wr(2'd2, 8'h01);
    for (int v = 0; v < NVEC; v++) begin
      miso_inv = MVEC[v][8];
      e0 = ecnt;
      wr(2'd1, MVEC[v][16:9]);
      rd(2'd0, r); chk("R2 txe cleared", {7'b0, r[1]}, 8'h00);
      rd(2'd0, r); chk("R2 txe restored", {7'b0, r[1]}, 8'h01);
      wait_done();
      chk("R2 edges", 8'(ecnt - e0), 8'd8);
      chk("R2 mosi msb first", cap, MVEC[v][16:9]);
      chk("R2 sck idle low", {7'b0, sck_out}, 8'h00);
      chk("R9 irq on done", {7'b0, irq}, 8'h01);
      rd(2'd1, r); chk("R2 rx byte", r, MVEC[v][7:0]);
      wr(2'd0, 8'h09);
      chk("R9 irq cleared", {7'b0, irq}, 8'h00);
    end
    miso_inv = 1'b0;

    // R4 write collision
    wr(2'd1, 8'h11);
    idle(3);
    wr(2'd1, 8'h22);
    wait_done();
    rd(2'd0, r); chk("R4 wcol set", {7'b0, r[6]}, 8'h01);
    rd(2'd1, r); chk("R4 first byte kept", r, 8'h11);
    idle(40);
    rd(2'd0, r); chk("R4 no second xfer txe", {7'b0, r[1]}, 8'h01);

    // R8 software load of flags, txe read-only
    wr(2'd0, 8'hF9);
    rd(2'd0, r); chk("R8 flags written", r, 8'hFB);
    chk("R9 irq from written flag", {7'b0, irq}, 8'h01);
    wr(2'd0, 8'h09);
    rd(2'd0, r); chk("R8 flags cleared", r, 8'h0B);

    // R7 single-master output follows mode bit 0
    wr(2'd0, 8'h0D);
    chk("R7 mode11 nss", {6'b0, nss_oe, nss_out}, 8'h03);
    wr(2'd0, 8'h09);
    chk("R7 mode10 nss", {6'b0, nss_oe, nss_out}, 8'h02);

    // R3 slave transfer in mode 01
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h05);
    nss_in = 1'b0;
    wr(2'd1, 8'h96);
    idle(3);
    rd(2'd0, r); chk("R3 txe after load", {7'b0, r[1]}, 8'h01);
    chk("R7 mode01 selected drives miso", {7'b0, miso_oe}, 8'h01);
    slave_xfer(8'h5A, seen);
    chk("R3 miso msb first", seen, 8'h96);
    rd(2'd0, r); chk("R3 done flag", {7'b0, r[7]}, 8'h01);
    rd(2'd1, r); chk("R3 rx byte", r, 8'h5A);
    wr(2'd0, 8'h05);

    // R6 overrun
    slave_xfer(8'h33, seen);
    slave_xfer(8'hEE, seen);
    rd(2'd0, r); chk("R6 overrun flag", {7'b0, r[4]}, 8'h01);
    rd(2'd1, r); chk("R6 old byte kept", r, 8'h33);
    wr(2'd0, 8'h05);
    slave_xfer(8'h44, seen);
    rd(2'd0, r); chk("R6 no overrun after read", {7'b0, r[4]}, 8'h00);
    rd(2'd1, r); chk("R6 rx after free", r, 8'h44);
    wr(2'd0, 8'h05);

    // R7 select behaviour
    nss_in = 1'b1;
    idle(4);
    chk("R7 mode01 deselected", {7'b0, miso_oe}, 8'h00);
    wr(2'd0, 8'h01);
    idle(2);
    chk("R7 mode00 ignores nss", {6'b0, miso_oe, nss_oe}, 8'h02);

    // R5 mode fault
    nss_in = 1'b0;
    wr(2'd0, 8'h05);
    wr(2'd2, 8'h01);
    idle(2);
    rd(2'd0, r); chk("R5 modf", {7'b0, r[5]}, 8'h01);
    rd(2'd2, r); chk("R5 master cleared", r, 8'h00);
    chk("R5 pins released", {6'b0, sck_oe, mosi_oe}, 8'h00);
    chk("R9 irq on fault", {7'b0, irq}, 8'h01);

    // R10 disabled
    nss_in = 1'b1;
    wr(2'd0, 8'h08);
    wr(2'd2, 8'h01);
    e0 = ecnt;
    wr(2'd1, 8'h77);
    idle(60);
    chk("R10 no edges", 8'(ecnt - e0), 8'd0);
    chk("R10 oe low", {4'b0, sck_oe, mosi_oe, miso_oe, nss_oe}, 8'h00);
    rd(2'd0, r); chk("R10 no done", {7'b0, r[7]}, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule